// File: doc/BRIEF.md
# Overlap-Aware Transfer Direction Planner

This block runs once at the start of a rectangle copy. It decides whether each scan line can be copied left to right in one pass, or whether it has to be cut into pieces and copied right to left. A start pulse captures three things: the copy flags, the source and destination positions, and the line width. Each position is a quadword index plus a 6-bit bit offset inside that quadword. One cycle later the block presents its results. These are the transfer mode, the signed distance in bits between destination and source, and a flag telling the memory side to touch every page of a line before the first write.

After that, a line is opened with a one-cycle request. The planner then sends the line's pieces (subitems) to the merge datapath over a valid/ready handshake. Each subitem carries a source bit offset, a destination bit offset, the matching word offsets and a length. When the last piece of a line has been accepted, the block pulses a line-end strobe. The caller counts lines down on that strobe and advances the addresses between lines itself.

Top module: `xfer_dir_planner`

## Requirements
- R1: One cycle after a start pulse is accepted, `done` is high for exactly one cycle. The results stay unchanged until the next accepted start. While a line is in progress, a start pulse is ignored: `done` stays low and the results keep their values.
- R2: The overlap evaluation runs only when `flag_backward`=1, `flag_disjoint`=0 and `flag_disjoint_lines`=0. Every other flag combination gives `rtl_mode`=0 and `force_touch`=0.
- R3: `nonoverlap` is a signed value. It equals 64 × (`dst_qw` − `src_qw`) + (`dst_bit` − `src_bit`), with the addresses read as unsigned numbers.
- R4: `force_touch` is 1 whenever the evaluation runs, whatever mode is then chosen.
- R5: When the evaluation runs, `rtl_mode` is 0 if `nonoverlap` < 64 (this includes negative values) or if the width is below 64. Otherwise `rtl_mode` is 1 exactly when width ≥ `nonoverlap`.
- R6: In left-to-right mode, a line with a nonzero width is sent as one subitem. Its source and destination offsets equal `src_bit` and `dst_bit`, and its length equals the width.
- R7: In right-to-left mode, the source and destination end pointers start at bit offset + width. Each subitem has length min(bits remaining, `nonoverlap`). Its offsets are end pointer − length, and after each subitem both end pointers move back by that length.
- R8: `sub_src_word` and `sub_dst_word` equal the matching subitem bit offset shifted right by 4.
- R9: `sub_valid` rises one cycle after an accepted `line_go`. While `sub_valid`=1 and `sub_ready`=0, all subitem fields hold their values. A subitem is consumed only in a cycle where both `sub_valid` and `sub_ready` are high.
- R10: `line_end` pulses for one cycle, one cycle after the last subitem is accepted. A line of width 0 sends no subitem and pulses `line_end` one cycle after `line_go`. A `line_go` that arrives during a line is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Capture inputs and plan a transfer |
| flag_backward | input | 1 | Transfer runs in the backward direction |
| flag_disjoint | input | 1 | Source and destination rectangles do not overlap |
| flag_disjoint_lines | input | 1 | Rectangles overlap but individual lines do not |
| src_qw | input | ADDR_W (16) | Source quadword index |
| dst_qw | input | ADDR_W (16) | Destination quadword index |
| src_bit | input | 6 | Source bit offset within its quadword |
| dst_bit | input | 6 | Destination bit offset within its quadword |
| line_width | input | WIDTH_W (15) | Line width in bits |
| line_go | input | 1 | Begin sending subitems for one line |
| sub_ready | input | 1 | Merge datapath accepts the current subitem |
| done | output | 1 | One-cycle pulse: plan results are valid |
| rtl_mode | output | 1 | Lines must be copied right to left in pieces |
| force_touch | output | 1 | Touch all pages of a line before writing |
| nonoverlap | output | ADDR_W+8 (24) | Signed destination-minus-source distance in bits |
| sub_valid | output | 1 | Subitem fields are valid |
| sub_src_off | output | WIDTH_W+1 (16) | Subitem source start bit offset |
| sub_dst_off | output | WIDTH_W+1 (16) | Subitem destination start bit offset |
| sub_src_word | output | WIDTH_W-3 (12) | Source start word offset |
| sub_dst_word | output | WIDTH_W-3 (12) | Destination start word offset |
| sub_len | output | WIDTH_W (15) | Subitem length in bits |
| line_end | output | 1 | One-cycle pulse: line finished |

## Verification
The plan results are registered once, so they are due at the first falling edge after the rising edge that takes the start. The bench samples `done`, `rtl_mode`, `force_touch` and `nonoverlap` there, and checks at the following falling edge that `done` has dropped. Subitem fields come directly from the line registers. They are due one edge after `line_go` and one edge after every accepted handshake, so the bench compares them at each falling edge, including edges where it holds `sub_ready` low. `line_end` is compared one edge after the final accepted subitem, or one edge after `line_go` for a line of zero width. The bench's expected values come from functions of its own that model the decision and the subitem stepping.

// File: rtl/xfer_dir_planner.sv
module xfer_dir_planner #(
  parameter int ADDR_W  = 16,
  parameter int WIDTH_W = 15
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    flag_backward,
  input  logic                    flag_disjoint,
  input  logic                    flag_disjoint_lines,
  input  logic [ADDR_W-1:0]       src_qw,
  input  logic [ADDR_W-1:0]       dst_qw,
  input  logic [5:0]              src_bit,
  input  logic [5:0]              dst_bit,
  input  logic [WIDTH_W-1:0]      line_width,
  input  logic                    line_go,
  input  logic                    sub_ready,
  output logic                    done,
  output logic                    rtl_mode,
  output logic                    force_touch,
  output logic [ADDR_W+7:0]       nonoverlap,
  output logic                    sub_valid,
  output logic [WIDTH_W:0]        sub_src_off,
  output logic [WIDTH_W:0]        sub_dst_off,
  output logic [WIDTH_W-4:0]      sub_src_word,
  output logic [WIDTH_W-4:0]      sub_dst_word,
  output logic [WIDTH_W-1:0]      sub_len,
  output logic                    line_end
);
  localparam int OFF_W = WIDTH_W + 1;
  localparam int NOV_W = ADDR_W + 8;
  localparam logic signed [NOV_W-1:0] QW_BITS = NOV_W'(64);

  logic signed [NOV_W-1:0] qdiff, bdiff, nov_c, wid_c, rem_ext, nov_q;
  logic                    eval_c, rtl_c, take_start, take_line, hs, last_hs;
  logic                    rtl_q, frc_q, done_q, busy_q, lend_q;
  logic [WIDTH_W-1:0]      width_q, rem_q, len_c;
  logic [5:0]              sbit_q, dbit_q;
  logic [OFF_W-1:0]        send_q, dend_q;

  assign eval_c = flag_backward & ~flag_disjoint & ~flag_disjoint_lines;
  assign qdiff  = $signed({{(NOV_W-ADDR_W){1'b0}}, dst_qw}) - $signed({{(NOV_W-ADDR_W){1'b0}}, src_qw});
  assign bdiff  = $signed({{(NOV_W-6){1'b0}}, dst_bit}) - $signed({{(NOV_W-6){1'b0}}, src_bit});
  assign nov_c  = (qdiff <<< 6) + bdiff;
  assign wid_c  = $signed({{(NOV_W-WIDTH_W){1'b0}}, line_width});
  assign rtl_c  = eval_c && (nov_c >= QW_BITS) && (wid_c >= QW_BITS) && (wid_c >= nov_c);

  assign take_start = start & ~busy_q;
  assign take_line  = line_go & ~busy_q & ~take_start;
  assign hs         = busy_q & sub_ready;

  assign rem_ext = $signed({{(NOV_W-WIDTH_W){1'b0}}, rem_q});
  assign len_c   = (rtl_q && rem_ext > nov_q) ? nov_q[WIDTH_W-1:0] : rem_q;
  assign last_hs = hs && (rem_q == len_c);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      rtl_q   <= 1'b0;
      frc_q   <= 1'b0;
      nov_q   <= '0;
      width_q <= '0;
      sbit_q  <= '0;
      dbit_q  <= '0;
    end else begin
      done_q <= take_start;
      if (take_start) begin
        rtl_q   <= rtl_c;
        frc_q   <= eval_c;
        nov_q   <= nov_c;
        width_q <= line_width;
        sbit_q  <= src_bit;
        dbit_q  <= dst_bit;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      lend_q <= 1'b0;
      rem_q  <= '0;
      send_q <= '0;
      dend_q <= '0;
    end else begin
      lend_q <= 1'b0;
      if (take_line) begin
        if (width_q == '0) begin
          lend_q <= 1'b1;
        end else begin
          busy_q <= 1'b1;
          rem_q  <= width_q;
          send_q <= {{(OFF_W-6){1'b0}}, sbit_q} + {1'b0, width_q};
          dend_q <= {{(OFF_W-6){1'b0}}, dbit_q} + {1'b0, width_q};
        end
      end else if (hs) begin
        rem_q  <= rem_q - len_c;
        send_q <= send_q - {1'b0, len_c};
        dend_q <= dend_q - {1'b0, len_c};
        if (last_hs) begin
          busy_q <= 1'b0;
          lend_q <= 1'b1;
        end
      end
    end
  end

  assign done         = done_q;
  assign rtl_mode     = rtl_q;
  assign force_touch  = frc_q;
  assign nonoverlap   = nov_q;
  assign sub_valid    = busy_q;
  assign sub_len      = len_c;
  assign sub_src_off  = send_q - {1'b0, len_c};
  assign sub_dst_off  = dend_q - {1'b0, len_c};
  assign sub_src_word = sub_src_off[OFF_W-1:4];
  assign sub_dst_word = sub_dst_off[OFF_W-1:4];
  assign line_end     = lend_q;

  p_done_after_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    take_start |=> done);

  p_rtl_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rtl_mode |-> force_touch && (nonoverlap >= QW_BITS));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sub_valid && !sub_ready |=> sub_valid && $stable(sub_src_off) && $stable(sub_dst_off) && $stable(sub_len));

  p_step_back_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sub_valid && sub_ready && !last_hs |=> (sub_src_off + {1'b0, sub_len}) == $past(sub_src_off));

  p_len_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sub_valid |-> (sub_len != '0) &&
      (!rtl_mode || $signed({{(NOV_W-WIDTH_W){1'b0}}, sub_len}) <= nonoverlap));

  p_end_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    line_end |-> !sub_valid);
endmodule

// File: tb/xfer_dir_planner_tb_top.sv
module xfer_dir_planner_tb_top;
  localparam int ADDR_W  = 16;
  localparam int WIDTH_W = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, flag_backward = 1'b0, flag_disjoint = 1'b0, flag_disjoint_lines = 1'b0;
  logic [ADDR_W-1:0] src_qw = '0, dst_qw = '0;
  logic [5:0] src_bit = '0, dst_bit = '0;
  logic [WIDTH_W-1:0] line_width = '0;
  logic line_go = 1'b0, sub_ready = 1'b0;
  logic done, rtl_mode, force_touch, sub_valid, line_end;
  logic [ADDR_W+7:0] nonoverlap;
  logic [WIDTH_W:0] sub_src_off, sub_dst_off;
  logic [WIDTH_W-4:0] sub_src_word, sub_dst_word;
  logic [WIDTH_W-1:0] sub_len;

  int checks = 0, failures = 0;
  int e_rtl, e_frc, e_nov, e_w, e_sb, e_db;

  xfer_dir_planner #(.ADDR_W(ADDR_W), .WIDTH_W(WIDTH_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .flag_backward(flag_backward),
    .flag_disjoint(flag_disjoint), .flag_disjoint_lines(flag_disjoint_lines),
    .src_qw(src_qw), .dst_qw(dst_qw), .src_bit(src_bit), .dst_bit(dst_bit),
    .line_width(line_width), .line_go(line_go), .sub_ready(sub_ready),
    .done(done), .rtl_mode(rtl_mode), .force_touch(force_touch), .nonoverlap(nonoverlap),
    .sub_valid(sub_valid), .sub_src_off(sub_src_off), .sub_dst_off(sub_dst_off),
    .sub_src_word(sub_src_word), .sub_dst_word(sub_dst_word), .sub_len(sub_len),
    .line_end(line_end));

  always #2 clk = ~clk;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int ref_nov(input int sq, input int dq, input int sb, input int db);
    return (dq - sq) * 64 + (db - sb);
  endfunction

  function automatic int ref_rtl(input bit ev, input int nov, input int w);
    if (!ev) return 0;
    if (nov < 64 || w < 64) return 0;
    return (w >= nov) ? 1 : 0;
  endfunction

  task automatic plan(input bit bk, input bit dj, input bit dl, input int sq, input int dq,
                      input int sb, input int db, input int w);
    bit ev;
    @(negedge clk);
    flag_backward = bk; flag_disjoint = dj; flag_disjoint_lines = dl;
    src_qw = sq[ADDR_W-1:0]; dst_qw = dq[ADDR_W-1:0];
    src_bit = sb[5:0]; dst_bit = db[5:0]; line_width = w[WIDTH_W-1:0];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    ev = bk && !dj && !dl;
    e_nov = ref_nov(sq & 16'hFFFF, dq & 16'hFFFF, sb & 63, db & 63);
    e_w = w; e_sb = sb & 63; e_db = db & 63;
    e_rtl = ref_rtl(ev, e_nov, w);
    e_frc = ev ? 1 : 0;
    chk("R1", "done pulse", done, 1);
    chk(ev ? "R5" : "R2", "rtl_mode", rtl_mode, e_rtl);
    chk(ev ? "R4" : "R2", "force_touch", force_touch, e_frc);
    chk("R3", "nonoverlap", int'($signed(nonoverlap)), e_nov);
    @(negedge clk);
    chk("R1", "done drops", done, 0);
  endtask

  task automatic run_line(input bit stall, input bit poke);
    int rem, se, de, len, guard;
    bit rdy, first;
    rem = e_w; se = e_sb + e_w; de = e_db + e_w; guard = 0; first = 1'b1;
    line_go = 1'b1;
    @(negedge clk);
    line_go = 1'b0;
    forever begin
      if (rem == 0) begin
        chk("R10", "line_end after last", line_end, 1);
        chk("R10", "valid low at end", sub_valid, 0);
        break;
      end
      len = (e_rtl != 0 && rem > e_nov) ? e_nov : rem;
      chk("R9", "sub_valid", sub_valid, 1);
      chk(e_rtl != 0 ? "R7" : "R6", "sub_len", sub_len, len);
      chk(e_rtl != 0 ? "R7" : "R6", "sub_src_off", sub_src_off, se - len);
      chk(e_rtl != 0 ? "R7" : "R6", "sub_dst_off", sub_dst_off, de - len);
      chk("R8", "sub_src_word", sub_src_word, (se - len) >> 4);
      chk("R8", "sub_dst_word", sub_dst_word, (de - len) >> 4);
      rdy = stall ? ($urandom % 3 != 0) : 1'b1;
      if (poke && first) begin
        rdy = 1'b0;
        start = 1'b1; line_go = 1'b1; flag_disjoint = ~flag_disjoint;
      end
      sub_ready = rdy;
      @(negedge clk);
      sub_ready = 1'b0;
      if (poke && first) begin
        start = 1'b0; line_go = 1'b0; flag_disjoint = ~flag_disjoint;
        chk("R1", "start ignored during line", done, 0);
      end
      first = 1'b0;
      if (rdy) begin
        se -= len; de -= len; rem -= len;
      end
      guard++;
      if (guard > 5000) begin
        chk("R10", "line never ended", 0, 1);
        break;
      end
    end
    @(negedge clk);
    chk("R10", "line_end single pulse", line_end, 0);
    chk("R1", "rtl_mode kept", rtl_mode, e_rtl);
    chk("R1", "nonoverlap kept", int'($signed(nonoverlap)), e_nov);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h1c0ffee));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "reset done", done, 0);
    chk("R9", "reset sub_valid", sub_valid, 0);
    chk("R10", "reset line_end", line_end, 0);
    chk("R2", "reset rtl_mode", rtl_mode, 0);

    plan(0, 0, 0, 100, 110, 3, 5, 900);    run_line(0, 0);
    plan(1, 1, 0, 100, 110, 3, 5, 900);
    plan(1, 0, 1, 100, 110, 3, 5, 900);
    plan(1, 0, 0, 100, 100, 4, 44, 500);   run_line(0, 0);
    plan(1, 0, 0, 100, 103, 0, 0, 50);     run_line(0, 0);
    plan(1, 0, 0, 100, 103, 0, 8, 100);
    plan(1, 0, 0, 100, 101, 0, 36, 300);   run_line(1, 1);
    plan(1, 0, 0, 200, 201, 10, 46, 250);  run_line(1, 0);
    plan(1, 0, 0, 200, 202, 0, 0, 128);    run_line(0, 0);
    plan(1, 0, 0, 300, 290, 0, 0, 2000);   run_line(0, 0);
    plan(1, 0, 0, 16'hFFFF, 0, 0, 0, 500);
    plan(1, 0, 0, 10, 12, 1, 2, 0);        run_line(0, 0);

    for (int i = 0; i < 150; i++) begin
      int sq, dq, w;
      bit bk, dj, dl;
      bk = ($urandom % 10) != 0;
      dj = ($urandom % 8) == 0;
      dl = ($urandom % 8) == 0;
      sq = $urandom % 65536;
      dq = (sq + int'($urandom % 40) - 8) & 16'hFFFF;
      w  = ($urandom % 4 == 0) ? int'($urandom % 128) : int'($urandom % 3000);
      plan(bk, dj, dl, sq, dq, $urandom % 64, $urandom % 64, w);
      run_line(1, (i % 25) == 3);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule